// File: doc/BRIEF.md
# Five-level carrier-comparison gate generator

This block drives the gates of a three-phase, five-level diode-clamped inverter. There are eight switches per leg. Each phase is steered by a signed 16-bit reference sample. The block runs one shared triangular carrier position counter, and from it derives four in-phase carriers. Each carrier sits in its own quarter of the signed reference range: two bands lie below zero and two above. Each clock, a phase's reference is compared with all four carriers. The number of carriers it exceeds selects one of five output levels. That level is decoded into a fixed eight-switch clamped-leg pattern.

The carrier frequency is set at run time by the step the carrier position moves each clock, so the ratio between carrier and reference frequency is programmable. Any phase can be pinned to the neutral level with its own flag, whatever its reference is. The four complementary switch pairs of each leg pass through a dead-time stage. This stage delays the turn-on of the incoming switch by a programmable number of clock cycles. The outgoing switch turns off at once.

Top module: `pd5_gate_gen`

## Requirements
- R1: While reset is asserted and after it is released, with neutral references, every leg shows the neutral pattern 8'h3C. Here bit i of a gate bus is switch S(i+1): S3, S4, S5 and S6 are on.
- R2: The carrier position starts at 0 and rises by `car_inc` per clock. When the sum would reach or pass 16383, it holds 16383 and turns downward. It then falls by `car_inc` per clock. When it would reach or pass 0, it holds 0 and turns upward. With `car_inc` = 0 it does not move.
- R3: Carrier k (k = 0..3) equals -32768 + 16384*k + position. The level index is the number of carriers that the reference exceeds strictly. Index 4 is +Vdc/2, 3 is +Vdc/4, 2 is 0, 1 is -Vdc/4 and 0 is -Vdc/2.
- R4: A reference of 32767 always gives index 4, and a reference of -32768 always gives index 0, whatever the carrier position.
- R5: Indices 0..4 decode to gate buses 8'hF0, 8'h78, 8'h3C, 8'h1E and 8'h0F. In order S1..S8 these read 00001111, 00011110, 00111100, 01111000 and 11110000.
- R6: Bits i and i+4 of a gate bus are a complementary pair and are never both on. With zero dead time, exactly four switches of a leg are on.
- R7: While `force_neu[p]` is set, phase p (0 = a, 1 = b, 2 = c) selects index 2, whatever its reference. The other phases are unaffected.
- R8: When a pair changes side, the outgoing switch is off after the next clock edge. The incoming switch stays off for `dead_cyc` further edges, and turns on at the edge after them.
- R9: With zero dead time, a new reference reaches the gates at the second rising edge after it is applied.
- R10: All three phases use the same carrier position and are evaluated on the same edge, each from its own reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| car_inc | input | 14 | Carrier position step per clock (sets carrier frequency) |
| dead_cyc | input | 8 | Dead-time length in clock cycles |
| ref_a | input | 16 | Signed reference, phase a |
| ref_b | input | 16 | Signed reference, phase b |
| ref_c | input | 16 | Signed reference, phase c |
| force_neu | input | 3 | Per-phase pin-to-neutral flags, bit 0 = phase a |
| gate_a | output | 8 | Gate bus, phase a, bit i = switch S(i+1) |
| gate_b | output | 8 | Gate bus, phase b |
| gate_c | output | 8 | Gate bus, phase c |

## Verification
The level selection is first tried with the carrier frozen at position 0. Here, references placed inside each band and exactly on a carrier value separate strict from non-strict comparison. Different references on the three phases at once expose any crosstalk or phase swap. A running carrier at a coarse step, with references in the upper, lower and outer bands, is then checked every cycle against a model of the triangle. This separates wrong turn-around points or step handling from correct ones. Full-scale references against a moving carrier show whether the saturation override is present. A single-band step and a full-swing step with dead time enabled show which pairs are gapped and for how long.

// File: rtl/pd5_pkg.sv
// Package: shared constants, level type and pair decode for the
// five-level gate generator. Assumes four complementary pairs per leg.
package pd5_pkg;

    localparam int NUM_PH    = 3;
    localparam int NUM_PAIRS = 4;
    localparam int NUM_CAR   = 4;
    localparam int NUM_SW    = 2 * NUM_PAIRS;

    // Level index: count of carriers the reference exceeds
    typedef enum logic [2:0] {
        LV_NEG2 = 3'd0,
        LV_NEG1 = 3'd1,
        LV_ZERO = 3'd2,
        LV_POS1 = 3'd3,
        LV_POS2 = 3'd4
    } lvl_e;

    // Upper switch of pair p is on when p + level reaches the pair count
    function automatic logic [NUM_PAIRS-1:0] upper_mask(lvl_e l);
        logic [NUM_PAIRS-1:0] m;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            m[p] = (p + int'(l)) >= NUM_PAIRS;
        end
        return m;
    endfunction

endpackage

// File: rtl/pd5_carrier.sv
// Module: shared triangular carrier position.
// Counts from 0 up to the band top by car_inc per clock, clamps at the
// top and reverses, clamps at 0 and reverses. A zero step freezes it.
// Assumes CNT_W-bit position whose all-ones value is the band top.
module pd5_carrier #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] car_inc,
    output logic [CNT_W-1:0] car_pos
);

    localparam logic [CNT_W:0] TOP_X = {1'b0, {CNT_W{1'b1}}};

    logic             up_q;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W:0]   sum_up;

    // Purpose: candidate position for the rising slope
    always_comb begin
        sum_up = {1'b0, pos_q} + {1'b0, car_inc};
    end

    // Purpose: advance the triangle and turn at either end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (sum_up >= TOP_X) begin
                pos_q <= TOP_X[CNT_W-1:0];
                up_q  <= 1'b0;
            end else begin
                pos_q <= sum_up[CNT_W-1:0];
            end
        end else begin
            if (pos_q <= car_inc) begin
                pos_q <= '0;
                up_q  <= 1'b1;
            end else begin
                pos_q <= pos_q - car_inc;
            end
        end
    end

    assign car_pos = pos_q;

endmodule

// File: rtl/pd5_level_sel.sv
// Module: per-phase level selector.
// Builds the four stacked carriers from the shared position, counts the
// carriers the reference strictly exceeds, applies full-scale saturation
// and the neutral override, and registers the level.
// Assumes carrier band height is a quarter of the reference range.
module pd5_level_sel
    import pd5_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int CNT_W = REF_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [CNT_W-1:0]        pos_i,
    input  logic                    force_i,
    output lvl_e                    lvl_o
);

    localparam int BAND = 1 << CNT_W;
    localparam logic [REF_W-1:0] REF_MAX = {1'b0, {(REF_W-1){1'b1}}};
    localparam logic [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

    logic signed [REF_W:0] ref_x;
    logic signed [REF_W:0] car_x [NUM_CAR];
    logic [NUM_CAR-1:0]    above;
    logic [2:0]            cnt;
    lvl_e                  lvl_q;

    assign ref_x = {ref_i[REF_W-1], ref_i};

    // One carrier and one comparator per amplitude band
    for (genvar k = 0; k < NUM_CAR; k++) begin : g_band
        localparam int BASE = -(1 << (REF_W-1)) + k * BAND;
        assign car_x[k] = (REF_W+1)'(BASE) + (REF_W+1)'(pos_i);
        assign above[k] = ref_x > car_x[k];
    end

    // Purpose: count the carriers lying below the reference
    always_comb begin
        cnt = '0;
        for (int k = 0; k < NUM_CAR; k++) begin
            cnt = cnt + 3'(above[k]);
        end
    end

    // Purpose: register the selected level with overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LV_ZERO;
        end else if (force_i) begin
            lvl_q <= LV_ZERO;
        end else if (ref_i == REF_MAX) begin
            lvl_q <= LV_POS2;
        end else if (ref_i == REF_MIN) begin
            lvl_q <= LV_NEG2;
        end else begin
            lvl_q <= lvl_e'(cnt);
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/pd5_pair_dt.sv
// Module: dead-time stage for one complementary switch pair.
// Tracks which side is on; on a side change the outgoing switch drops at
// once and the incoming one waits dead_cyc cycles. Assumes want_hi is a
// registered signal.
module pd5_pair_dt #(
    parameter int   DT_W   = 8,
    parameter logic RST_HI = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want_hi,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            on_hi,
    output logic            on_lo
);

    logic            side_q;
    logic [DT_W-1:0] wait_q;
    logic            idle;

    // Purpose: follow the wanted side and run the gap counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= RST_HI;
            wait_q <= '0;
        end else if (want_hi != side_q) begin
            side_q <= want_hi;
            wait_q <= dead_cyc;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - DT_W'(1);
        end
    end

    // Purpose: enable the chosen side only once the gap has run out
    always_comb begin
        idle  = (wait_q == '0);
        on_hi = side_q && idle;
        on_lo = !side_q && idle;
    end

endmodule

// File: rtl/pd5_gate_gen.sv
// Module: three-phase five-level carrier-comparison gate generator (top).
// One shared carrier position feeds a level selector per phase; each
// level is decoded to four pair wants, each passed through a dead-time
// stage. Gate bus bit i is switch S(i+1); pair p is bits p and p+4.
module pd5_gate_gen
    import pd5_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int DT_W  = 8,
    parameter int CNT_W = REF_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        car_inc,
    input  logic [DT_W-1:0]         dead_cyc,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    input  logic [NUM_PH-1:0]       force_neu,
    output logic [NUM_SW-1:0]       gate_a,
    output logic [NUM_SW-1:0]       gate_b,
    output logic [NUM_SW-1:0]       gate_c
);

    logic [CNT_W-1:0]        car_pos;
    logic signed [REF_W-1:0] ref_arr  [NUM_PH];
    logic [NUM_SW-1:0]       gate_arr [NUM_PH];
    logic [3*NUM_PH-1:0]     lvl_all;

    assign ref_arr[0] = ref_a;
    assign ref_arr[1] = ref_b;
    assign ref_arr[2] = ref_c;

    pd5_carrier #(.CNT_W(CNT_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .car_inc (car_inc),
        .car_pos (car_pos)
    );

    // One selector and four dead-time pairs per phase
    for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
        lvl_e                 lvl;
        logic [NUM_PAIRS-1:0] want;

        pd5_level_sel #(.REF_W(REF_W), .CNT_W(CNT_W)) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_i   (ref_arr[g]),
            .pos_i   (car_pos),
            .force_i (force_neu[g]),
            .lvl_o   (lvl)
        );

        assign want = upper_mask(lvl);
        assign lvl_all[3*g +: 3] = lvl;

        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            pd5_pair_dt #(
                .DT_W   (DT_W),
                .RST_HI (p >= NUM_PAIRS / 2)
            ) u_dt (
                .clk      (clk),
                .rst_n    (rst_n),
                .want_hi  (want[p]),
                .dead_cyc (dead_cyc),
                .on_hi    (gate_arr[g][p]),
                .on_lo    (gate_arr[g][p+NUM_PAIRS])
            );
        end
    end

    assign gate_a = gate_arr[0];
    assign gate_b = gate_arr[1];
    assign gate_c = gate_arr[2];

endmodule

// File: rtl/pd5_gate_chk.sv
// Module: property checker for pd5_gate_gen, attached by bind.
// Watches ports plus the registered levels and carrier position.
module pd5_gate_chk #(
    parameter int REF_W = 16,
    parameter int DT_W  = 8,
    parameter int CNT_W = REF_W - 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CNT_W-1:0]        car_inc,
    input logic [DT_W-1:0]         dead_cyc,
    input logic signed [REF_W-1:0] ref_a,
    input logic [2:0]              force_neu,
    input logic [7:0]              gate_a,
    input logic [7:0]              gate_b,
    input logic [7:0]              gate_c,
    input logic [2:0]              lvl_a,
    input logic [CNT_W-1:0]        car_pos
);

    localparam logic [REF_W-1:0] REF_MAX = {1'b0, {(REF_W-1){1'b1}}};

    // R2
    car_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_inc == '0) |=> $stable(car_pos));

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_a == REF_MAX) && !force_neu[0] |=> (lvl_a == 3'd4));

    // R6
    pair_excl_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a[3:0] & gate_a[7:4]) == 4'b0000);

    // R6
    pair_excl_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_b[3:0] & gate_b[7:4]) == 4'b0000);

    // R6
    pair_excl_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_c[3:0] & gate_c[7:4]) == 4'b0000);

    // R6
    four_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_a) <= 4);

    // R7
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_neu[0] |=> (lvl_a == 3'd2));

    // R8
    gap_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_a[4]) && (dead_cyc != '0) |-> !gate_a[0]);

endmodule

bind pd5_gate_gen pd5_gate_chk #(
    .REF_W (REF_W),
    .DT_W  (DT_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .car_inc   (car_inc),
    .dead_cyc  (dead_cyc),
    .ref_a     (ref_a),
    .force_neu (force_neu),
    .gate_a    (gate_a),
    .gate_b    (gate_b),
    .gate_c    (gate_c),
    .lvl_a     (lvl_all[2:0]),
    .car_pos   (car_pos)
);

// File: tb/pd5_gate_gen_test.sv
// Directed bench for pd5_gate_gen: one task per scenario, each checking
// its own results against a level model built from the requirements.
module pd5_gate_gen_test;

    localparam time CLK_P = 20ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [13:0]        car_inc = '0;
    logic [7:0]         dead_cyc = '0;
    logic signed [15:0] ref_a = '0;
    logic signed [15:0] ref_b = '0;
    logic signed [15:0] ref_c = '0;
    logic [2:0]         force_neu = '0;
    logic [7:0]         gate_a, gate_b, gate_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    pd5_gate_gen uut (
        .clk(clk), .rst_n(rst_n), .car_inc(car_inc), .dead_cyc(dead_cyc),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .force_neu(force_neu),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
    );

    always #(CLK_P/2) clk = ~clk;

    // Gate pattern for a level index (R5)
    function automatic logic [7:0] pat(int l);
        case (l)
            0: return 8'hF0;
            1: return 8'h78;
            2: return 8'h3C;
            3: return 8'h1E;
            default: return 8'h0F;
        endcase
    endfunction

    // Level index from reference, flag and carrier position (R3, R4, R7)
    function automatic int lvl_of(logic signed [15:0] r, logic f, int pos);
        int n = 0;
        if (f) return 2;
        if (r == 16'sh7FFF) return 4;
        if (r == 16'sh8000) return 0;
        for (int k = 0; k < 4; k++)
            if (int'(r) > -32768 + k * 16384 + pos) n++;
        return n;
    endfunction

    // Carrier and two-stage level model (R2, R9)
    int m_pos = 0;
    bit m_up = 1;
    int m1 [3] = '{2, 2, 2};
    int m2 [3] = '{2, 2, 2};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos <= 0; m_up <= 1;
            for (int i = 0; i < 3; i++) begin m1[i] <= 2; m2[i] <= 2; end
        end else begin
            m1[0] <= lvl_of(ref_a, force_neu[0], m_pos);
            m1[1] <= lvl_of(ref_b, force_neu[1], m_pos);
            m1[2] <= lvl_of(ref_c, force_neu[2], m_pos);
            for (int i = 0; i < 3; i++) m2[i] <= m1[i];
            if (m_up) begin
                if (m_pos + int'(car_inc) >= 16383) begin m_pos <= 16383; m_up <= 0; end
                else m_pos <= m_pos + int'(car_inc);
            end else begin
                if (m_pos <= int'(car_inc)) begin m_pos <= 0; m_up <= 1; end
                else m_pos <= m_pos - int'(car_inc);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(3);
        chk("R1 reset a", gate_a, 8'h3C);
        chk("R1 reset b", gate_b, 8'h3C);
        chk("R1 reset c", gate_c, 8'h3C);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 after release a", gate_a, 8'h3C);
    endtask

    // Frozen carrier at 0: bands, boundaries, latency, phase independence
    task automatic t_static;
        ref_a = -16'sd20000; ref_b = 16'sd5000; ref_c = 16'sd20000;
        cyc(1);
        chk("R9 one edge a", gate_a, 8'h3C);
        cyc(1);
        chk("R9 two edges a / R5 -Vdc/4", gate_a, 8'h78);
        chk("R10 phase b +Vdc/4", gate_b, 8'h1E);
        chk("R10 phase c +Vdc/2", gate_c, 8'h0F);
        ref_a = 16'sd0; ref_b = 16'sd16384; ref_c = -16'sd16384;
        cyc(3);
        chk("R3 equal to carrier 0", gate_a, 8'h3C);
        chk("R3 equal to carrier 16384", gate_b, 8'h1E);
        chk("R3 equal to carrier -16384", gate_c, 8'h78);
        ref_a = 16'sd1; ref_b = -16'sd100; ref_c = 16'sh8000;
        cyc(3);
        chk("R3 just above 0", gate_a, 8'h1E);
        chk("R6 four on zero level", 8'($countones(gate_b)), 8'd4);
        chk("R5 -Vdc/2", gate_c, 8'hF0);
    endtask

    // Dead time on a one-band step and a full-swing step
    task automatic t_dead;
        ref_a = -16'sd100; ref_b = -16'sd100; ref_c = -16'sd100;
        cyc(4);
        dead_cyc = 8'd3;
        cyc(2);
        ref_a = 16'sd20000;
        cyc(1);
        chk("R8 level only", gate_a, 8'h3C);
        for (int i = 0; i < 3; i++) begin
            cyc(1);
            chk("R8 gap 0 to +Vdc/2", gate_a, 8'h0C);
        end
        cyc(1);
        chk("R8 incoming on", gate_a, 8'h0F);
        ref_a = 16'sh8000;
        cyc(2);
        for (int i = 0; i < 3; i++) begin
            chk("R8 full swing gap", gate_a, 8'h00);
            cyc(1);
        end
        chk("R8 full swing done", gate_a, 8'hF0);
        chk("R6 other phase steady", gate_b, 8'h3C);
        dead_cyc = 8'd0;
        cyc(2);
    endtask

    task automatic t_force;
        ref_a = -16'sd100; ref_b = 16'sd20000; ref_c = -16'sd20000;
        cyc(3);
        chk("R7 before flag", gate_b, 8'h0F);
        force_neu = 3'b010;
        cyc(2);
        chk("R7 forced b", gate_b, 8'h3C);
        chk("R7 a untouched", gate_a, 8'h3C);
        chk("R7 c untouched", gate_c, 8'h78);
        ref_b = 16'sh8000;
        cyc(3);
        chk("R7 ref ignored", gate_b, 8'h3C);
        force_neu = 3'b000;
        cyc(2);
        chk("R7 released", gate_b, 8'hF0);
    endtask

    // Running carrier checked every cycle against the model
    task automatic t_carrier;
        ref_a = 16'sd8000; ref_b = -16'sd8000; ref_c = 16'sd24000;
        car_inc = 14'd3000;
        cyc(1);
        for (int i = 0; i < 60; i++) begin
            cyc(1);
            chk("R2/R3 carrier a", gate_a, pat(m2[0]));
            chk("R2/R3 carrier b", gate_b, pat(m2[1]));
            chk("R10 carrier c", gate_c, pat(m2[2]));
            if (i == 30) ref_a = -16'sd24000;
        end
    endtask

    task automatic t_sat;
        car_inc = 14'd1000;
        ref_a = 16'sh7FFF; ref_b = 16'sh8000; ref_c = 16'sd0;
        cyc(3);
        for (int i = 0; i < 40; i++) begin
            chk("R4 top saturation", gate_a, 8'h0F);
            chk("R4 bottom saturation", gate_b, 8'hF0);
            cyc(1);
        end
    endtask

    initial begin
        t_reset;
        t_static;
        t_dead;
        t_force;
        t_carrier;
        t_sat;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule